// File: doc/BRIEF.md
# Marker-Framed Serial Word Receiver with Odd-Parity Check

This block builds fixed-width data words from a bit-serial read stream. A one bit arrives as a read pulse during a strobe cycle. A zero bit arrives as no pulse at all. A separate shift pulse advances the frame by one bit position. Each frame carries `WORD_W` data bits, most significant first, followed by one parity bit. Together the frame's ones must make an odd count.

The block needs no bit counter. When it is armed, the shift register is cleared and a single marker one is planted at its least significant end. Received bits enter behind the marker, so the marker climbs toward the top as bits arrive. The frame is complete on the shift that pushes the marker out of the top stage. On that same edge the parity result is folded into a sticky error flag, and the marker and parity tracker are re-armed for the next frame.

A completed word goes to the holding buffer only while the current sector count equals the target sector address. The buffer load is announced by a one-cycle transfer request. The block also counts completed words and pulses a sector-end output when the last word of a sector completes.

Top module: `serial_word_reader`

## Requirements
- R1: While reset is asserted and directly after it, `word_o` is 0 and `xfer_req_o`, `par_err_o` and `sector_end_o` are 0.
- R2: A bit counts as one only in a cycle where both `strobe_i` and `rd_pulse_i` are high. Bits enter at the least significant end, so the first data bit of a frame ends at `word_o[WORD_W-1]` and the last data bit at `word_o[0]`. The parity bit is not stored.
- R3: A frame completes on exactly the `WORD_W+1`-th shift since the last completion or arm, and never earlier.
- R4: A completed word is loaded into `word_o` only if `sector_cnt_i == sector_adr_i` in the cycle of the completing shift. Otherwise `word_o` keeps its value and no request is raised.
- R5: `xfer_req_o` is high for exactly the one cycle following the completing shift edge.
- R6: `par_err_o` rises on the completing shift edge when the frame's data bits plus parity bit contain an even number of ones.
- R7: `par_err_o` stays set through later frames until `arm_i` is pulsed.
- R8: `arm_i` (setup or continue command) clears `par_err_o`, discards a partly received frame, re-plants the marker and resets the word count. It takes priority over a shift or read pulse in the same cycle.
- R9: Frames follow one another without a gap. The shift after a completion is the first bit position of the next frame, with no arm in between.
- R10: `sector_end_o` pulses together with the completion of every `WORDS_PER_SECT`-th word counted since arm. The count then wraps to zero.
- R11: A read pulse without the strobe has no effect on the received bit value or on parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Setup/continue command: restart framing and clear the error |
| strobe_i | input | 1 | Read strobe qualifying `rd_pulse_i` |
| rd_pulse_i | input | 1 | High for a one bit read from the track |
| shift_i | input | 1 | Advance the frame by one bit position |
| sector_cnt_i | input | SECT_W | Current sector count |
| sector_adr_i | input | SECT_W | Target sector address |
| word_o | output | WORD_W | Holding buffer with the last transferred word |
| xfer_req_o | output | 1 | One-cycle transfer request |
| par_err_o | output | 1 | Sticky parity-error flag |
| sector_end_o | output | 1 | Pulse on completion of the last word of a sector |

## Verification
The bench keeps the full 12-bit word width, so the marker has to climb through all thirteen stages before a frame completes. It shrinks `WORDS_PER_SECT` to 4, which lets the sector-end pulse and the counter wrap occur twice within a short run, including after an arm has reset the count. With `SECT_W` left at 3, matching and mismatching sector addresses are both easy to present, along with stray unstrobed read pulses and an arm in the middle of a frame.

// File: rtl/swr_pkg.sv
package swr_pkg;
   localparam int unsigned SWR_WORD_W_DEF = 12;
   localparam int unsigned SWR_WORDS_DEF  = 128;
   localparam int unsigned SWR_SECT_W_DEF = 3;

   function automatic bit swr_is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/swr_marker_shift.sv
module swr_marker_shift #(
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              bit_i,
   input  logic              shift_i,
   output logic              done_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int unsigned FRAME_W = WORD_W + 1;
   localparam logic [FRAME_W-1:0] MARK = FRAME_W'(1);

   logic [FRAME_W-1:0] sh_q;
   logic               stage_q;
   logic [FRAME_W-1:0] frame_nxt;

   // bits enter at the LSB, the marker climbs ahead of them
   assign frame_nxt = {sh_q[FRAME_W-2:0], stage_q};
   // marker in the top stage: this shift moves it into overflow
   assign done_o    = shift_i & sh_q[FRAME_W-1] & ~arm_i;
   assign word_o    = frame_nxt[FRAME_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= MARK;
         stage_q <= 1'b0;
      end else if (arm_i) begin
         sh_q    <= MARK;
         stage_q <= 1'b0;
      end else if (shift_i) begin
         sh_q    <= done_o ? MARK : frame_nxt;
         stage_q <= bit_i;
      end else if (bit_i) begin
         stage_q <= 1'b1;
      end
   end
endmodule

// File: rtl/swr_parity.sv
module swr_parity (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic bit_i,
   input  logic done_i,
   output logic err_o
);
   logic par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b1;
         err_o <= 1'b0;
      end else if (arm_i) begin
         par_q <= 1'b1;
         err_o <= 1'b0;
      end else if (done_i) begin
         err_o <= err_o | par_q;
         par_q <= ~bit_i;
      end else if (bit_i) begin
         par_q <= ~par_q;
      end
   end
endmodule

// File: rtl/swr_gate.sv
module swr_gate
   import swr_pkg::*;
#(
   parameter int unsigned WORD_W         = 12,
   parameter int unsigned WORDS_PER_SECT = 128,
   parameter int unsigned SECT_W         = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              done_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [SECT_W-1:0] sector_cnt_i,
   input  logic [SECT_W-1:0] sector_adr_i,
   output logic [WORD_W-1:0] word_o,
   output logic              req_o,
   output logic              end_o
);
   localparam int unsigned CNT_W = $clog2(WORDS_PER_SECT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS_PER_SECT - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             hit;
   logic             last;

   assign hit  = (sector_cnt_i == sector_adr_i);
   assign last = (cnt_q == LAST);

   generate
      if (swr_is_pow2(WORDS_PER_SECT)) begin : g_wrap_nat
         assign cnt_inc = cnt_q + CNT_W'(1);
      end else begin : g_wrap_cmp
         assign cnt_inc = last ? '0 : cnt_q + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         word_o <= '0;
         req_o  <= 1'b0;
         end_o  <= 1'b0;
      end else begin
         req_o <= done_i & hit;
         end_o <= done_i & last;
         if (arm_i) begin
            cnt_q <= '0;
         end else if (done_i) begin
            cnt_q <= cnt_inc;
         end
         if (done_i && hit) begin
            word_o <= word_i;
         end
      end
   end
endmodule

// File: rtl/serial_word_reader.sv
module serial_word_reader
   import swr_pkg::*;
#(
   parameter int unsigned WORD_W         = SWR_WORD_W_DEF,
   parameter int unsigned WORDS_PER_SECT = SWR_WORDS_DEF,
   parameter int unsigned SECT_W         = SWR_SECT_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              strobe_i,
   input  logic              rd_pulse_i,
   input  logic              shift_i,
   input  logic [SECT_W-1:0] sector_cnt_i,
   input  logic [SECT_W-1:0] sector_adr_i,
   output logic [WORD_W-1:0] word_o,
   output logic              xfer_req_o,
   output logic              par_err_o,
   output logic              sector_end_o
);
   generate
      if (WORD_W < 2) begin : g_bad_word_w
         $error("serial_word_reader: WORD_W must be at least 2");
      end
      if (WORDS_PER_SECT < 2) begin : g_bad_words
         $error("serial_word_reader: WORDS_PER_SECT must be at least 2");
      end
      if (SECT_W < 1) begin : g_bad_sect_w
         $error("serial_word_reader: SECT_W must be at least 1");
      end
   endgenerate

   logic              one_bit;
   logic              done;
   logic [WORD_W-1:0] rx_word;

   assign one_bit = strobe_i & rd_pulse_i;

   swr_marker_shift #(.WORD_W(WORD_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (arm_i),
      .bit_i  (one_bit),
      .shift_i(shift_i),
      .done_o (done),
      .word_o (rx_word)
   );

   swr_parity u_par (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_i (arm_i),
      .bit_i (one_bit),
      .done_i(done),
      .err_o (par_err_o)
   );

   swr_gate #(
      .WORD_W        (WORD_W),
      .WORDS_PER_SECT(WORDS_PER_SECT),
      .SECT_W        (SECT_W)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm_i),
      .done_i      (done),
      .word_i      (rx_word),
      .sector_cnt_i(sector_cnt_i),
      .sector_adr_i(sector_adr_i),
      .word_o      (word_o),
      .req_o       (xfer_req_o),
      .end_o       (sector_end_o)
   );
endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
   parameter int unsigned WORD_W = 12,
   parameter int unsigned SECT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm_i,
   input logic              shift_i,
   input logic [SECT_W-1:0] sector_cnt_i,
   input logic [SECT_W-1:0] sector_adr_i,
   input logic [WORD_W-1:0] word_o,
   input logic              xfer_req_o,
   input logic              par_err_o,
   input logic              sector_end_o
);
   localparam int unsigned FRAME_W = WORD_W + 1;
   localparam int unsigned SC_W    = $clog2(FRAME_W + 1);
   localparam logic [SC_W-1:0] SC_LAST = SC_W'(FRAME_W - 1);

   logic [SC_W-1:0] shifts_q;
   logic            complete;

   assign complete = shift_i && !arm_i && (shifts_q == SC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shifts_q <= '0;
      end else if (arm_i) begin
         shifts_q <= '0;
      end else if (shift_i) begin
         shifts_q <= complete ? '0 : shifts_q + SC_W'(1);
      end
   end

   p_req_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o |-> $past(complete));

   p_req_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o |-> $past(sector_cnt_i == sector_adr_i));

   p_buf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_req_o |-> $stable(word_o));

   p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o |=> !xfer_req_o);

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(par_err_o) && !$past(arm_i)) |-> par_err_o);

   p_arm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> !par_err_o);

   p_end_after_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sector_end_o |-> $past(complete));
endmodule

bind serial_word_reader swr_checker #(
   .WORD_W(WORD_W),
   .SECT_W(SECT_W)
) u_swr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arm_i       (arm_i),
   .shift_i     (shift_i),
   .sector_cnt_i(sector_cnt_i),
   .sector_adr_i(sector_adr_i),
   .word_o      (word_o),
   .xfer_req_o  (xfer_req_o),
   .par_err_o   (par_err_o),
   .sector_end_o(sector_end_o)
);

// File: tb/tb_serial_word_reader.sv
`timescale 1ns/1ps
module tb_serial_word_reader;
   localparam int WW = 12;
   localparam int NW = 4;
   localparam int SW = 3;
   localparam int FW = WW + 1;

   typedef struct packed {
      logic [WW-1:0] w;
      logic          err;
      logic          last;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm_i = 1'b0;
   logic          strobe_i = 1'b0;
   logic          rd_pulse_i = 1'b0;
   logic          shift_i = 1'b0;
   logic [SW-1:0] sector_cnt_i = '0;
   logic [SW-1:0] sector_adr_i = 3'd3;
   logic [WW-1:0] word_o;
   logic          xfer_req_o;
   logic          par_err_o;
   logic          sector_end_o;

   int   n_chk = 0;
   int   n_bad = 0;
   exp_t sb_q[$];
   bit   exp_err = 1'b0;
   int   word_idx = 0;
   int   exp_ends = 0;
   int   got_ends = 0;
   logic [WW-1:0] last_buf = '0;
   bit   done_flag = 1'b0;

   always #5 clk = ~clk;

   serial_word_reader #(
      .WORD_W(WW), .WORDS_PER_SECT(NW), .SECT_W(SW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .strobe_i(strobe_i),
      .rd_pulse_i(rd_pulse_i), .shift_i(shift_i),
      .sector_cnt_i(sector_cnt_i), .sector_adr_i(sector_adr_i),
      .word_o(word_o), .xfer_req_o(xfer_req_o), .par_err_o(par_err_o),
      .sector_end_o(sector_end_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // driver: one frame, MSB-first data then parity bit
   task automatic send_frame(input logic [WW-1:0] w, input bit bad_par,
                             input bit match, input bit ghost);
      logic [FW-1:0] fr;
      logic          p;
      exp_t          e;
      p  = ~(^w) ^ bad_par;
      fr = {w, p};
      sector_cnt_i = match ? 3'd3 : 3'd5;
      for (int i = FW - 1; i >= 0; i--) begin
         @(negedge clk);
         if (fr[i]) begin
            strobe_i = 1'b1; rd_pulse_i = 1'b1;
         end else if (ghost) begin
            strobe_i = 1'b0; rd_pulse_i = 1'b1;   // R11 unstrobed pulse
         end
         @(negedge clk);
         strobe_i = 1'b0; rd_pulse_i = 1'b0;
         if (i == 0) begin
            chk("R3 no request before final shift", {31'd0, xfer_req_o}, 32'd0);
            if (($countones(fr) % 2) == 0) exp_err = 1'b1;
            e.w = w; e.err = exp_err; e.last = (word_idx == NW - 1);
            if (e.last) exp_ends++;
            word_idx = (word_idx + 1) % NW;
            if (match) begin
               sb_q.push_back(e);
               last_buf = w;
            end
         end
         shift_i = 1'b1;
         @(negedge clk);
         shift_i = 1'b0;
      end
      @(negedge clk);
      if (!match) chk("R4 buffer held on sector mismatch", {20'd0, word_o}, {20'd0, last_buf});
   endtask

   // monitor: compare outputs against queued expectations
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && sector_end_o) got_ends++;
         if (rst_n && xfer_req_o) begin
            if (sb_q.size() == 0) begin
               chk("R4 unexpected transfer request", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk("R2 word value", {20'd0, word_o}, {20'd0, e.w});
               chk("R6/R7 parity flag", {31'd0, par_err_o}, {31'd0, e.err});
               chk("R10 sector end with word", {31'd0, sector_end_o}, {31'd0, e.last});
               @(posedge clk);
               #1;
               chk("R5 request lasts one cycle", {31'd0, xfer_req_o}, 32'd0);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 word in reset", {20'd0, word_o}, 32'd0);
      chk("R1 request in reset", {31'd0, xfer_req_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 error after reset", {31'd0, par_err_o}, 32'd0);
      chk("R1 sector end after reset", {31'd0, sector_end_o}, 32'd0);

      // R9 back-to-back frames, several patterns
      send_frame(12'hA5C, 1'b0, 1'b1, 1'b0);
      send_frame(12'h000, 1'b0, 1'b1, 1'b0);
      send_frame(12'hFFF, 1'b0, 1'b1, 1'b0);
      send_frame(12'h123, 1'b0, 1'b0, 1'b0);   // R4 mismatch, 4th word: R10 end
      send_frame(12'h7E4, 1'b0, 1'b1, 1'b0);
      send_frame(12'h3C1, 1'b1, 1'b1, 1'b0);   // R6 bad parity
      send_frame(12'h801, 1'b0, 1'b1, 1'b0);   // R7 flag stays
      chk("R7 flag still set", {31'd0, par_err_o}, 32'd1);

      // R8: partial frame then arm
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); strobe_i = 1'b1; rd_pulse_i = 1'b1;
         @(negedge clk); strobe_i = 1'b0; rd_pulse_i = 1'b0; shift_i = 1'b1;
         @(negedge clk); shift_i = 1'b0;
      end
      @(negedge clk); arm_i = 1'b1;
      @(negedge clk); arm_i = 1'b0;
      exp_err = 1'b0; word_idx = 0;
      chk("R8 arm clears error", {31'd0, par_err_o}, 32'd0);
      send_frame(12'h5A3, 1'b0, 1'b1, 1'b0);
      send_frame(12'h0F0, 1'b0, 1'b1, 1'b1);   // R11 ghost pulses
      send_frame(12'h9C6, 1'b0, 1'b1, 1'b1);
      send_frame(12'h444, 1'b0, 1'b1, 1'b0);   // R10 wrap after arm
      send_frame(12'hB2D, 1'b0, 1'b1, 1'b0);

      repeat (4) @(negedge clk);
      chk("R5 all transfers delivered", sb_q.size(), 32'd0);
      chk("R10 sector end count", got_ends, exp_ends);
      done_flag = 1'b1;
      summary();
   end
endmodule